// File: doc/BRIEF.md
# Dual-Edge Pulse Width Capture Unit

This unit measures the high and low phases of one asynchronous digital signal in cycles of its own clock. The input passes through a synchronizer, and every level change it detects restarts a free-running width counter. At that moment the count reached is kept. A falling edge files the count as a high-phase width and a rising edge files it as a low-phase width. Each edge type has its own two-entry history, in which the newest capture pushes the older one down.

Each edge type has an event flag that stays set until software clears it with a one-cycle clear strobe. An interrupt line combines the flags that are enabled. Per-type valid indicators hide the partial measurements taken after any reset. Overrun flags record captures that land while the previous event is still unserviced. A sticky saturation flag marks a phase longer than the counter can hold. A synchronous soft reset restarts the measurement without disturbing the synchronizer.

Top module: `pwcap_top`

## Requirements
- R1: The width counter returns to zero in the cycle after each detected edge or soft reset and then rises by one per clock. It saturates at all-ones (1023 for a 10-bit counter) and does not wrap.
- R2: A falling edge writes the counter value into fall slot 0 and moves the old fall slot 0 into fall slot 1. A high phase of N clocks reads back as N-1.
- R3: A rising edge writes the counter value into rise slot 0 and moves the old rise slot 0 into rise slot 1. A low phase of N clocks reads back as N-1.
- R4: A rising edge sets `rise_flag` and a falling edge sets `fall_flag`. Each flag stays set until its clear input is high at a clock edge. A new edge in that same cycle wins over the clear.
- R5: `irq` is high exactly when `rise_flag & irq_en[0]` or `fall_flag & irq_en[1]` is true.
- R6: `rise_valid` and `fall_valid` are low after reset or soft reset. Each rises with the second capture of its own edge type and stays high until the next reset.
- R7: An edge that arrives while its own event flag is still set sets that type's sticky overrun flag. Both overrun flags are cleared by `clr_ovr`.
- R8: `sat_flag` sets once the counter holds all-ones and stays set until `clr_sat`.
- R9: Soft reset clears the counter, all four slots, all flags and both valid indicators.
- R10: `rd_sel` selects the slot: 0 is rise slot 0, 1 is rise slot 1, 2 is fall slot 0, 3 is fall slot 1.
- R11: After hard reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restart of measurement state |
| sig_in | input | 1 | Asynchronous signal under measurement |
| irq_en | input | 2 | Interrupt enables: bit 0 rise, bit 1 fall |
| clr_rise | input | 1 | Clear strobe for the rise flag |
| clr_fall | input | 1 | Clear strobe for the fall flag |
| clr_ovr | input | 1 | Clear strobe for both overrun flags |
| clr_sat | input | 1 | Clear strobe for the saturation flag |
| rd_sel | input | SEL_W (2) | Slot select for rd_data |
| rd_data | output | CNT_W (16) | Selected captured count |
| rise_flag | output | 1 | Rising-edge event pending |
| fall_flag | output | 1 | Falling-edge event pending |
| rise_valid | output | 1 | Rise slot 0 holds a genuine width |
| fall_valid | output | 1 | Fall slot 0 holds a genuine width |
| rise_ovr | output | 1 | Rise capture overrun |
| fall_ovr | output | 1 | Fall capture overrun |
| sat_flag | output | 1 | Counter reached all-ones |
| irq | output | 1 | Combined enabled event request |

## Verification
The scoreboard drives pulse trains whose high and low lengths differ: asymmetric, equal, long high with short low, and short high with long low. A swap of the rise and fall histories, or an off-by-one in the counter restart, therefore shows up as a wrong number. Reading slot 1 next to slot 0 on every event tells a correct shift apart from a history that is overwritten or never moves. The first capture of each type after a reset and after a soft reset must come out invalid, while the later ones must be valid and exact. Separate directed sequences hold the input low past the counter range to show saturation instead of wraparound. They also leave flags uncleared so that overrun is recorded only for the edge type still pending.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
   localparam int EDGE_RISE = 0;
   localparam int EDGE_FALL = 1;
   localparam int NUM_EDGES = 2;
   typedef logic [NUM_EDGES-1:0] edge_vec_t;
endpackage

// File: rtl/pwcap_sync_edge.sv
module pwcap_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_async,
   output logic rise_det,
   output logic fall_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwcap_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], sig_async};
         prev_q  <= level;
      end
   end

   assign level    = chain_q[STAGES-1];
   assign rise_det = level & ~prev_q;
   assign fall_det = ~level & prev_q;

   // R1: an edge lasts one cycle, so the restart fires once per edge
   a_r1_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise_det |=> !rise_det);
   a_r1_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
      fall_det |=> !fall_det);
endmodule

// File: rtl/pwcap_counter.sv
module pwcap_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   output logic [W-1:0] count,
   output logic         at_max
);
   generate
      if (W < 2) begin : g_bad_width
         $error("pwcap_counter: W must be at least 2");
      end
   endgenerate

   localparam logic [W-1:0] CMAX = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clear)         cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
   end

   assign count  = cnt_q;
   assign at_max = (cnt_q == CMAX);

   a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));
   a_r1_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (at_max && !clear) |=> at_max);
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!at_max && !clear) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/pwcap_history.sv
module pwcap_history #(
   parameter int W     = 16,
   parameter int DEPTH = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic                      cap,
   input  logic [W-1:0]              din,
   output logic [DEPTH-1:0][W-1:0]   slots
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pwcap_history: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0][W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (flush) begin
         slot_q <= '0;
      end else if (cap) begin
         slot_q[0] <= din;
         for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_q[i-1];
      end
   end

   assign slots = slot_q;

   // R2 / R3: newest capture lands in slot 0, older one moves down
   a_r2_newest: assert property (@(posedge clk) disable iff (!rst_n || flush)
      cap |=> (slots[0] == $past(din)));
   a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n || flush)
      cap |=> (slots[1] == $past(slots[0])));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n || flush)
      !cap |=> $stable(slots));
endmodule

// File: rtl/pwcap_evflag.sv
module pwcap_evflag #(
   parameter int VALID_AFTER = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic set,
   input  logic clr,
   input  logic clr_ovr,
   output logic flag,
   output logic ovr,
   output logic valid
);
   generate
      if (VALID_AFTER < 1) begin : g_bad_valid
         $error("pwcap_evflag: VALID_AFTER must be at least 1");
      end
   endgenerate

   localparam int VW = $clog2(VALID_AFTER + 1);
   localparam logic [VW-1:0] VTARGET = VW'(VALID_AFTER);

   logic          flag_q;
   logic          ovr_q;
   logic [VW-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ovr_q  <= 1'b0;
         seen_q <= '0;
      end else if (flush) begin
         flag_q <= 1'b0;
         ovr_q  <= 1'b0;
         seen_q <= '0;
      end else begin
         if (set)      flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;
         if (set && flag_q) ovr_q <= 1'b1;
         else if (clr_ovr)  ovr_q <= 1'b0;
         if (set && seen_q != VTARGET) seen_q <= seen_q + 1'b1;
      end
   end

   assign flag  = flag_q;
   assign ovr   = ovr_q;
   assign valid = (seen_q == VTARGET);

   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n || flush)
      set |=> flag);
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (flag && !clr) |=> flag);
   a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (set && flag) |=> ovr);
   a_r6_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n || flush)
      valid |=> valid);
endmodule

// File: rtl/pwcap_top.sv
module pwcap_top
   import pwcap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int HIST_DEPTH  = 2,
   parameter int SYNC_STAGES = 2,
   parameter int VALID_AFTER = 2,
   localparam int SEL_W      = $clog2(NUM_EDGES * HIST_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             sig_in,
   input  logic [1:0]       irq_en,
   input  logic             clr_rise,
   input  logic             clr_fall,
   input  logic             clr_ovr,
   input  logic             clr_sat,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [CNT_W-1:0] rd_data,
   output logic             rise_flag,
   output logic             fall_flag,
   output logic             rise_valid,
   output logic             fall_valid,
   output logic             rise_ovr,
   output logic             fall_ovr,
   output logic             sat_flag,
   output logic             irq
);
   generate
      if ((HIST_DEPTH & (HIST_DEPTH - 1)) != 0) begin : g_bad_hist
         $error("pwcap_top: HIST_DEPTH must be a power of two");
      end
   endgenerate

   edge_vec_t edge_det, clr_vec, flag_vec, ovr_vec, valid_vec;
   logic [CNT_W-1:0] count;
   logic             at_max;
   logic             sat_q;
   logic [NUM_EDGES-1:0][HIST_DEPTH-1:0][CNT_W-1:0] hist;

   pwcap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_async(sig_in),
      .rise_det (edge_det[EDGE_RISE]),
      .fall_det (edge_det[EDGE_FALL])
   );

   pwcap_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (soft_rst | (|edge_det)),
      .count (count),
      .at_max(at_max)
   );

   assign clr_vec[EDGE_RISE] = clr_rise;
   assign clr_vec[EDGE_FALL] = clr_fall;

   for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
      pwcap_history #(.W(CNT_W), .DEPTH(HIST_DEPTH)) u_hist (
         .clk  (clk),
         .rst_n(rst_n),
         .flush(soft_rst),
         .cap  (edge_det[e]),
         .din  (count),
         .slots(hist[e])
      );
      pwcap_evflag #(.VALID_AFTER(VALID_AFTER)) u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .flush  (soft_rst),
         .set    (edge_det[e]),
         .clr    (clr_vec[e]),
         .clr_ovr(clr_ovr),
         .flag   (flag_vec[e]),
         .ovr    (ovr_vec[e]),
         .valid  (valid_vec[e])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sat_q <= 1'b0;
      else if (soft_rst) sat_q <= 1'b0;
      else if (at_max)   sat_q <= 1'b1;
      else if (clr_sat)  sat_q <= 1'b0;
   end

   assign rd_data    = hist[rd_sel[SEL_W-1]][rd_sel[SEL_W-2:0]];
   assign rise_flag  = flag_vec[EDGE_RISE];
   assign fall_flag  = flag_vec[EDGE_FALL];
   assign rise_valid = valid_vec[EDGE_RISE];
   assign fall_valid = valid_vec[EDGE_FALL];
   assign rise_ovr   = ovr_vec[EDGE_RISE];
   assign fall_ovr   = ovr_vec[EDGE_FALL];
   assign sat_flag   = sat_q;
   assign irq        = |(flag_vec & irq_en);

   // R8: a saturated counter always leaves the flag set
   a_r8_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      at_max |=> sat_flag);
   // R9: soft reset empties the measurement state
   a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!rise_flag && !fall_flag && !rise_valid && !fall_valid && !sat_flag));
   // R5: no request without an enabled pending flag
   a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_flag && !fall_flag) |-> !irq);
endmodule

// File: tb/pwcap_top_bench.sv
`timescale 1ns/1ps
module pwcap_top_bench;
   localparam int W    = 10;
   localparam int CMAX = (1 << W) - 1;

   logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, sig_in = 1'b0;
   logic [1:0] irq_en = 2'b00;
   logic clr_rise = 1'b0, clr_fall = 1'b0, clr_ovr = 1'b0, clr_sat = 1'b0;
   logic [1:0] rd_sel = 2'd0;
   logic [W-1:0] rd_data;
   logic rise_flag, fall_flag, rise_valid, fall_valid, rise_ovr, fall_ovr, sat_flag, irq;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0, mon_en = 1'b0, track = 1'b0;
   bit first_r, first_f, prev_r_ok, prev_f_ok;
   int last_low, prev_r0, prev_f0;
   int rq[$];
   int fq[$];

   always #2.5 clk = ~clk;

   pwcap_top #(.CNT_W(W)) u_pwcap_top (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sig_in(sig_in), .irq_en(irq_en),
      .clr_rise(clr_rise), .clr_fall(clr_fall), .clr_ovr(clr_ovr), .clr_sat(clr_sat),
      .rd_sel(rd_sel), .rd_data(rd_data), .rise_flag(rise_flag), .fall_flag(fall_flag),
      .rise_valid(rise_valid), .fall_valid(fall_valid), .rise_ovr(rise_ovr),
      .fall_ovr(fall_ovr), .sat_flag(sat_flag), .irq(irq)
   );

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int capped(int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   // driver: one high phase of h clocks then one low phase of l clocks
   task automatic pulse(int h, int l);
      sig_in = 1'b1;
      if (track) begin
         rq.push_back(first_r ? -1 : capped(last_low - 1));
         first_r = 1'b0;
      end
      repeat (h) @(negedge clk);
      sig_in = 1'b0;
      if (track) begin
         fq.push_back(first_f ? -1 : capped(h - 1));
         first_f = 1'b0;
      end
      last_low = l;
      repeat (l) @(negedge clk);
   endtask

   task automatic start_track();
      first_r = 1'b1; first_f = 1'b1; prev_r_ok = 1'b0; prev_f_ok = 1'b0;
      track = 1'b1; mon_en = 1'b1;
   endtask

   task automatic drain();
      int guard = 0;
      while ((rq.size() != 0 || fq.size() != 0) && guard < 200) begin
         @(negedge clk); guard++;
      end
      repeat (4) @(negedge clk);
      check("R2/R3 scoreboard drained", rq.size() + fq.size(), 0);
      track = 1'b0; mon_en = 1'b0;
   endtask

   // monitor: pops expected widths when an event flag appears
   initial begin
      forever begin
         @(negedge clk);
         clr_rise = 1'b0; clr_fall = 1'b0;
         if (mon_en && rise_flag) begin
            int s0, s1, exp;
            rd_sel = 2'd0; #0.4 s0 = int'(rd_data);
            rd_sel = 2'd1; #0.4 s1 = int'(rd_data);
            if (rq.size() == 0) begin
               check("R3 unexpected rise event", 1, 0);
            end else begin
               exp = rq.pop_front();
               if (exp < 0) check("R6 rise_valid low on first capture", int'(rise_valid), 0);
               else begin
                  check("R6 rise_valid high", int'(rise_valid), 1);
                  check("R3 rise slot0 low width", s0, exp);
               end
               if (prev_r_ok) check("R3 rise slot1 shifted", s1, prev_r0);
            end
            prev_r0 = s0; prev_r_ok = 1'b1;
            clr_rise = 1'b1;
         end
         if (mon_en && fall_flag) begin
            int s0, s1, exp;
            rd_sel = 2'd2; #0.4 s0 = int'(rd_data);
            rd_sel = 2'd3; #0.4 s1 = int'(rd_data);
            if (fq.size() == 0) begin
               check("R2 unexpected fall event", 1, 0);
            end else begin
               exp = fq.pop_front();
               if (exp < 0) check("R6 fall_valid low on first capture", int'(fall_valid), 0);
               else begin
                  check("R6 fall_valid high", int'(fall_valid), 1);
                  check("R2 fall slot0 high width", s0, exp);
               end
               if (prev_f_ok) check("R2 fall slot1 shifted", s1, prev_f0);
            end
            prev_f0 = s0; prev_f_ok = 1'b1;
            clr_fall = 1'b1;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 rise_flag", int'(rise_flag), 0);
      check("R11 fall_flag", int'(fall_flag), 0);
      check("R11 valid", int'(rise_valid | fall_valid), 0);
      check("R11 overrun", int'(rise_ovr | fall_ovr), 0);
      check("R11 sat_flag", int'(sat_flag), 0);
      check("R11 irq", int'(irq), 0);
      for (int i = 0; i < 4; i++) begin
         rd_sel = 2'(i); #0.4;
         check("R11 R10 slot zero", int'(rd_data), 0);
      end

      // scoreboard run after hard reset
      start_track();
      pulse(5, 7); pulse(4, 4); pulse(12, 3); pulse(3, 9); pulse(20, 6); pulse(6, 20);
      pulse(7, 5);
      drain();

      // R5 / R4 / R7 directed
      irq_en = 2'b11;
      pulse(4, 4); repeat (3) @(negedge clk);
      check("R4 rise_flag set", int'(rise_flag), 1);
      check("R4 fall_flag set", int'(fall_flag), 1);
      check("R5 irq both enabled", int'(irq), 1);
      irq_en = 2'b00; #0.4;
      check("R5 irq none enabled", int'(irq), 0);
      irq_en = 2'b01; #0.4;
      check("R5 irq rise enabled", int'(irq), 1);
      clr_rise = 1'b1; @(negedge clk); clr_rise = 1'b0;
      check("R4 rise_flag cleared", int'(rise_flag), 0);
      check("R4 fall_flag kept", int'(fall_flag), 1);
      check("R5 irq after rise clear", int'(irq), 0);
      irq_en = 2'b10; #0.4;
      check("R5 irq fall enabled", int'(irq), 1);
      pulse(4, 4); repeat (3) @(negedge clk);
      check("R7 fall_ovr set", int'(fall_ovr), 1);
      check("R7 rise_ovr clear", int'(rise_ovr), 0);
      clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
      check("R7 overrun cleared", int'(rise_ovr | fall_ovr), 0);
      clr_rise = 1'b1; clr_fall = 1'b1; @(negedge clk);
      clr_rise = 1'b0; clr_fall = 1'b0; irq_en = 2'b00;

      // R8 / R1 saturation
      repeat (CMAX + 60) @(negedge clk);
      check("R8 sat_flag set", int'(sat_flag), 1);
      pulse(5, 6); repeat (2) @(negedge clk);
      rd_sel = 2'd0; #0.4;
      check("R1 saturated low width", int'(rd_data), CMAX);
      rd_sel = 2'd2; #0.4;
      check("R2 high width after saturation", int'(rd_data), 4);
      clr_sat = 1'b1; @(negedge clk); clr_sat = 1'b0;
      check("R8 sat_flag cleared", int'(sat_flag), 0);

      // R9 soft reset
      soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
      check("R9 flags cleared", int'(rise_flag | fall_flag), 0);
      check("R9 valid cleared", int'(rise_valid | fall_valid), 0);
      for (int i = 0; i < 4; i++) begin
         rd_sel = 2'(i); #0.4;
         check("R9 slot cleared", int'(rd_data), 0);
      end

      // scoreboard run after soft reset
      start_track();
      pulse(8, 5); pulse(3, 3); pulse(9, 14); pulse(5, 5);
      drain();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule